// File: doc/BRIEF.md
# Programmable Line Divider and Clamp Pulse Generator

This block counts master-clock dots across one horizontal line and derives two kinds of line-rate timing from that count. The first is a reference pulse for an external phase-locked loop. It is high for the first half of every line and is offered in true and inverted form. In graphics mode the line length is set by an 11-bit divide value that holds the line length minus one. In the two television modes the line length is a fixed constant, and the divide value is not used.

The second kind is a pair of active-low clamp strobes for the video front end. The two strobes have different fixed widths. They move together across four start positions chosen by a 2-bit setting, and a 7-bit horizontal position value shifts them further. A position value of 64 means no shift. Each start position is saturated so that its strobe always fits inside the line.

Top module: `line_clamp_gen`

## Requirements
- R1: With `vga_sel` = 1 the line is `div_val` + 1 dots long. The dot count returns to 0 on the clock after it reaches or exceeds `div_val`, so lowering `div_val` below the current count mid-line starts a new line within one clock.
- R2: With `vga_sel` = 0 the line is 816 dots long, whatever `div_val` holds.
- R3: Mode decode: `vga_sel` = 1 selects graphics mode whatever `ntsc_sel` is. With `vga_sel` = 0, `ntsc_sel` = 1 selects NTSC and `ntsc_sel` = 0 selects PAL. Both television modes use the 816-dot line.
- R4: Outside reset, `cmp_pulse_n` is always the inverse of `cmp_pulse`.
- R5: `cmp_pulse` is high for the first (L+1)/2 dots of each line (L = line length, integer division) and low for the rest, so its rising edge marks dot 0.
- R6: `clamp1_n` is low for 40 consecutive dots. With `hpos` = 64 the low window starts 74, 81, 88 or 95 dots after dot 0 for `clamp_sel` = 0, 1, 2, 3.
- R7: `clamp2_n` is low for 67 consecutive dots. With `hpos` = 64 the low window starts 61, 68, 75 or 82 dots after dot 0 for `clamp_sel` = 0, 1, 2, 3.
- R8: Both clamp start positions move by (`hpos` − 64) dots.
- R9: A clamp start that would fall below dot 0 is held at dot 0. A start that would let the strobe run past the end of the line is held at L minus the strobe width.
- R10: While reset is active, both clamp outputs are high, `cmp_pulse` is 0 and `cmp_pulse_n` is 1. After release the dot count starts at 0, so the first line is a complete line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master dot clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vga_sel | input | 1 | 1 selects graphics mode, 0 selects a television mode |
| ntsc_sel | input | 1 | In television mode: 1 selects NTSC, 0 selects PAL |
| div_val | input | 11 | Graphics-mode line length minus one |
| hpos | input | 7 | Horizontal start position; 64 gives no shift |
| clamp_sel | input | 2 | Picks one of four clamp positions |
| cmp_pulse | output | 1 | Line-rate reference, high in the first half of the line |
| cmp_pulse_n | output | 1 | Inverse of cmp_pulse |
| clamp1_n | output | 1 | Narrow clamp strobe, active low |
| clamp2_n | output | 1 | Wide clamp strobe, active low |

## Verification
The line function is exercised with an even graphics length (800), an odd length (801), and both television settings while the divide value holds a graphics length. These cases separate the programmed length from the fixed 816, and they separate rounding from truncation in the half-line pulse. The clamp strobes are measured from the reference rising edge in four situations: two position settings at neutral shift, a positive shift, a shift that would push the wide strobe before dot 0, and a 100-dot line where both strobes hit the end-of-line limit. Together these show the per-strobe base, step, shift and both saturation bounds. A final case lowers the divide value in the second half of a long line and checks that the next line starts within a clock.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

  typedef enum logic [1:0] {
    MODE_PAL  = 2'd0,
    MODE_NTSC = 2'd1,
    MODE_VGA  = 2'd2
  } lcg_mode_e;

  localparam int unsigned LCG_NUM_CLAMPS = 2;
  // index 0 drives the narrow strobe, index 1 the wide one
  localparam int unsigned LCG_CLAMP_BASE  [LCG_NUM_CLAMPS] = '{74, 61};
  localparam int unsigned LCG_CLAMP_WIDTH [LCG_NUM_CLAMPS] = '{40, 67};

endpackage

// File: rtl/lcg_line_len.sv
module lcg_line_len
  import lcg_pkg::*;
#(
  parameter int unsigned DIV_W   = 11,
  parameter int unsigned LEN_W   = DIV_W + 1,
  parameter int unsigned TV_LINE = 816
) (
  input  logic             vga_sel_i,
  input  logic             ntsc_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] last_o,
  output logic [LEN_W-1:0] len_o,
  output logic [LEN_W-1:0] half_o
);

  localparam logic [DIV_W-1:0] TV_LAST = DIV_W'(TV_LINE - 1);

  lcg_mode_e mode;

  always_comb begin
    if (vga_sel_i)       mode = MODE_VGA;
    else if (ntsc_sel_i) mode = MODE_NTSC;
    else                 mode = MODE_PAL;
  end

  always_comb begin
    unique case (mode)
      MODE_VGA:  last_o = div_i;
      MODE_NTSC: last_o = TV_LAST;
      MODE_PAL:  last_o = TV_LAST;
      default:   last_o = TV_LAST;
    endcase
  end

  assign len_o  = LEN_W'(last_o) + LEN_W'(1);
  assign half_o = LEN_W'((len_o + LEN_W'(1)) >> 1);

endmodule

// File: rtl/lcg_dot_cnt.sv
module lcg_dot_cnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (cnt_q >= last_i) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= last_i) |=> (cnt_q == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < last_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/lcg_clamp.sv
module lcg_clamp #(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned HP_W   = 7,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned BASE   = 74,
  parameter int unsigned WIDTH  = 40,
  parameter int unsigned STEP   = 7,
  parameter int unsigned HP_REF = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [HP_W-1:0]  hpos_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clamp_n_o
);

  localparam int unsigned SUM_W = LEN_W + 1;
  localparam logic [SUM_W-1:0] BASE_V  = SUM_W'(BASE);
  localparam logic [SUM_W-1:0] WIDTH_V = SUM_W'(WIDTH);
  localparam logic [SUM_W-1:0] STEP_V  = SUM_W'(STEP);
  localparam logic [SUM_W-1:0] REF_V   = SUM_W'(HP_REF);

  logic [SUM_W-1:0] sum_w;
  logic [SUM_W-1:0] raw_w;
  logic [SUM_W-1:0] lim_w;
  logic [SUM_W-1:0] start_w;
  logic [SUM_W-1:0] cnt_ext;
  logic [SUM_W-1:0] len_ext;
  logic             active_w;
  logic             clamp_n_d;
  logic             clamp_n_q;

  assign cnt_ext = SUM_W'(cnt_i);
  assign len_ext = SUM_W'(len_i);

  always_comb begin
    sum_w   = BASE_V + STEP_V * SUM_W'(sel_i) + SUM_W'(hpos_i);
    raw_w   = (sum_w < REF_V) ? '0 : sum_w - REF_V;
    lim_w   = (len_ext > WIDTH_V) ? len_ext - WIDTH_V : '0;
    start_w = (raw_w > lim_w) ? lim_w : raw_w;
  end

  always_comb begin
    active_w  = (cnt_ext >= start_w) && (cnt_ext < start_w + WIDTH_V);
    clamp_n_d = ~active_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_n_q <= 1'b1;
    else        clamp_n_q <= clamp_n_d;
  end

  assign clamp_n_o = clamp_n_q;

  assert_clamp_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_ext == start_w) && (len_ext > WIDTH_V)) |=> !clamp_n_o);

  assert_clamp_before_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ext < start_w) |=> clamp_n_o);

  assert_clamp_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (len_ext > WIDTH_V) |-> (start_w + WIDTH_V <= len_ext));

endmodule

// File: rtl/line_clamp_gen.sv
module line_clamp_gen
  import lcg_pkg::*;
#(
  parameter int unsigned DIV_W      = 11,
  parameter int unsigned HP_W       = 7,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned TV_LINE    = 816,
  parameter int unsigned HP_REF     = 64,
  parameter int unsigned CLAMP_STEP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vga_sel,
  input  logic             ntsc_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic [HP_W-1:0]  hpos,
  input  logic [SEL_W-1:0] clamp_sel,
  output logic             cmp_pulse,
  output logic             cmp_pulse_n,
  output logic             clamp1_n,
  output logic             clamp2_n
);

  localparam int unsigned CNT_W = DIV_W;
  localparam int unsigned LEN_W = DIV_W + 1;

  logic             rst_meta_q;
  logic             rst_sync_q;
  logic [CNT_W-1:0] last_w;
  logic [LEN_W-1:0] len_w;
  logic [LEN_W-1:0] half_w;
  logic [CNT_W-1:0] cnt_w;
  logic             cmp_d;
  logic             cmp_q;
  logic             cmp_n_q;
  logic [LCG_NUM_CLAMPS-1:0] clamp_n_w;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lcg_line_len #(
    .DIV_W  (DIV_W),
    .LEN_W  (LEN_W),
    .TV_LINE(TV_LINE)
  ) u_len (
    .vga_sel_i (vga_sel),
    .ntsc_sel_i(ntsc_sel),
    .div_i     (div_val),
    .last_o    (last_w),
    .len_o     (len_w),
    .half_o    (half_w)
  );

  lcg_dot_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .last_i(last_w),
    .cnt_o (cnt_w)
  );

  for (genvar g = 0; g < LCG_NUM_CLAMPS; g++) begin : g_clamp
    lcg_clamp #(
      .CNT_W (CNT_W),
      .LEN_W (LEN_W),
      .HP_W  (HP_W),
      .SEL_W (SEL_W),
      .BASE  (LCG_CLAMP_BASE[g]),
      .WIDTH (LCG_CLAMP_WIDTH[g]),
      .STEP  (CLAMP_STEP),
      .HP_REF(HP_REF)
    ) u_clamp (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .cnt_i    (cnt_w),
      .len_i    (len_w),
      .hpos_i   (hpos),
      .sel_i    (clamp_sel),
      .clamp_n_o(clamp_n_w[g])
    );
  end

  assign cmp_d = (LEN_W'(cnt_w) < half_w);

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      cmp_q   <= 1'b0;
      cmp_n_q <= 1'b1;
    end else begin
      cmp_q   <= cmp_d;
      cmp_n_q <= ~cmp_d;
    end
  end

  assign cmp_pulse   = cmp_q;
  assign cmp_pulse_n = cmp_n_q;
  assign clamp1_n    = clamp_n_w[0];
  assign clamp2_n    = clamp_n_w[1];

  assert_cmp_compl_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cmp_pulse_n == !cmp_pulse);

  assert_cmp_lead_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cnt_w == '0) |=> cmp_pulse);

  assert_cmp_tail_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (LEN_W'(cnt_w) >= half_w) |=> !cmp_pulse);

endmodule

// File: tb/line_clamp_gen_tb.sv
module line_clamp_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vga_sel;
  logic        ntsc_sel;
  logic [10:0] div_val;
  logic [6:0]  hpos;
  logic [1:0]  clamp_sel;
  logic        cmp_pulse;
  logic        cmp_pulse_n;
  logic        clamp1_n;
  logic        clamp2_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  line_clamp_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .vga_sel    (vga_sel),
    .ntsc_sel   (ntsc_sel),
    .div_val    (div_val),
    .hpos       (hpos),
    .clamp_sel  (clamp_sel),
    .cmp_pulse  (cmp_pulse),
    .cmp_pulse_n(cmp_pulse_n),
    .clamp1_n   (clamp1_n),
    .clamp2_n   (clamp2_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d cycles", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise(output int waited);
    bit prev;
    waited = 0;
    prev = cmp_pulse;
    do begin
      @(negedge clk);
      waited++;
      if (cmp_pulse && !prev) break;
      prev = cmp_pulse;
    end while (waited < 5000);
  endtask

  // measures one whole line starting at a rising edge of cmp_pulse
  task automatic measure(output int per, output int hi, output int f1, output int w1,
                         output int f2, output int w2, output int bad);
    int w;
    bit prev;
    wait_rise(w);
    per = 0; hi = 0; f1 = -1; w1 = 0; f2 = -1; w2 = 0; bad = 0;
    prev = 1'b0;
    do begin
      if (cmp_pulse_n != !cmp_pulse) bad++;
      if (cmp_pulse) hi++;
      if (!clamp1_n) begin if (f1 < 0) f1 = per; w1++; end
      if (!clamp2_n) begin if (f2 < 0) f2 = per; w2++; end
      prev = cmp_pulse;
      @(negedge clk);
      per++;
    end while (!(cmp_pulse && !prev) && per < 5000);
  endtask

  task automatic setup(input bit v, input bit n, input int d, input int h, input int s);
    @(negedge clk);
    vga_sel = v; ntsc_sel = n; div_val = 11'(d); hpos = 7'(h); clamp_sel = 2'(s);
  endtask

  task automatic t_reset;
    int w;
    rst_n = 1'b0;
    setup(1, 0, 799, 64, 0);
    repeat (3) @(negedge clk);
    chk(clamp1_n, 1, "R10 clamp1_n in reset");
    chk(clamp2_n, 1, "R10 clamp2_n in reset");
    chk(cmp_pulse, 0, "R10 cmp_pulse in reset");
    chk(cmp_pulse_n, 1, "R10 cmp_pulse_n in reset");
    rst_n = 1'b1;
    wait_rise(w);
    chk(int'(w <= 5), 1, "R10 first line starts right after release");
  endtask

  task automatic t_vga_base;
    int p, h, f1, w1, f2, w2, b;
    setup(1, 0, 799, 64, 0);
    measure(p, h, f1, w1, f2, w2, b);
    chk(p, 800, "R1 line length div 799");
    chk(h, 400, "R5 high dots L=800");
    chk(b, 0, "R4 complement mismatches");
    chk(f1, 74, "R6 clamp1 start sel 0");
    chk(w1, 40, "R6 clamp1 width");
    chk(f2, 61, "R7 clamp2 start sel 0");
    chk(w2, 67, "R7 clamp2 width");
  endtask

  task automatic t_vga_sel;
    int p, h, f1, w1, f2, w2, b;
    setup(1, 0, 799, 64, 3);
    measure(p, h, f1, w1, f2, w2, b);
    chk(f1, 95, "R6 clamp1 start sel 3");
    chk(f2, 82, "R7 clamp2 start sel 3");
    setup(1, 0, 799, 64, 1);
    measure(p, h, f1, w1, f2, w2, b);
    chk(f1, 81, "R6 clamp1 start sel 1");
    chk(f2, 68, "R7 clamp2 start sel 1");
  endtask

  task automatic t_hshift;
    int p, h, f1, w1, f2, w2, b;
    setup(1, 0, 799, 97, 2);
    measure(p, h, f1, w1, f2, w2, b);
    chk(f1, 121, "R8 clamp1 start hpos 97 sel 2");
    chk(f2, 108, "R8 clamp2 start hpos 97 sel 2");
    chk(w1, 40, "R8 clamp1 width kept");
  endtask

  task automatic t_tv_modes;
    int p, h, f1, w1, f2, w2, b;
    setup(0, 1, 599, 64, 0);
    measure(p, h, f1, w1, f2, w2, b);
    chk(p, 816, "R2 NTSC line length");
    chk(h, 408, "R5 high dots L=816");
    chk(f1, 74, "R2 clamp1 start in NTSC");
    setup(0, 0, 599, 64, 0);
    measure(p, h, f1, w1, f2, w2, b);
    chk(p, 816, "R3 PAL line length");
    chk(b, 0, "R4 complement in PAL");
    setup(1, 1, 599, 64, 0);
    measure(p, h, f1, w1, f2, w2, b);
    chk(p, 600, "R3 vga_sel overrides ntsc_sel");
  endtask

  task automatic t_odd_len;
    int p, h, f1, w1, f2, w2, b;
    setup(1, 0, 800, 64, 0);
    measure(p, h, f1, w1, f2, w2, b);
    chk(p, 801, "R1 line length div 800");
    chk(h, 401, "R5 high dots L=801");
  endtask

  task automatic t_sat_low;
    int p, h, f1, w1, f2, w2, b;
    setup(1, 0, 799, 0, 0);
    measure(p, h, f1, w1, f2, w2, b);
    chk(f1, 10, "R8 clamp1 start hpos 0");
    chk(f2, 0, "R9 clamp2 held at dot 0");
    chk(w2, 67, "R9 clamp2 width at dot 0");
  endtask

  task automatic t_sat_high;
    int p, h, f1, w1, f2, w2, b;
    setup(1, 0, 99, 127, 3);
    measure(p, h, f1, w1, f2, w2, b);
    chk(p, 100, "R1 short line div 99");
    chk(f1, 60, "R9 clamp1 held at L-40");
    chk(w1, 40, "R9 clamp1 width at end");
    chk(f2, 33, "R9 clamp2 held at L-67");
    chk(w2, 67, "R9 clamp2 width at end");
  endtask

  task automatic t_shrink;
    int w;
    setup(1, 0, 799, 64, 0);
    wait_rise(w);
    repeat (600) @(negedge clk);
    div_val = 11'd99;
    wait_rise(w);
    chk(int'(w <= 3), 1, "R1 wrap after mid-line shrink");
  endtask

  initial begin
    rst_n = 1'b0;
    vga_sel = 1'b1; ntsc_sel = 1'b0; div_val = 11'd799; hpos = 7'd64; clamp_sel = 2'd0;
    t_reset();
    t_vga_base();
    t_vga_sel();
    t_hshift();
    t_tv_modes();
    t_odd_len();
    t_sat_low();
    t_sat_high();
    t_shrink();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule